// File: doc/BRIEF.md
# Gated Periodic Pulse Generator

This block produces a train of short, fixed-width pulses. One of two repetition periods is selected with a level input. The whole function runs only while a start level is held high, and an indicator output shows when generation is running. Two free-running tick dividers derive a fine tick of about one millisecond and a coarse tick of about 65.5 ms from the system clock. The pulse width is counted in fine ticks. The repetition period is counted in coarse ticks: a modulo-16 count gives the short period of about one second, and a modulo-62 count gives the long period of about four seconds.

While start is low, the period counter is held at zero. As a result, the first coarse tick seen after start goes high fires a pulse at once. Each firing samples the rate-select level and holds it for the whole period that follows, so a change of rate never shortens or stretches a period that is already running. Dropping start ends any pulse in progress on the next clock and turns the indicator off. The divider lengths are parameters, so a shortened timebase can be used without changing the 16:62 period ratio or the width in fine ticks.

Top module: `gated_pulse_train`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `pulse_out` and `active_led` are 0. The period counter is at zero and the rate is held as short.
- R2: `active_led` equals `start_in` as sampled on the previous rising clock edge.
- R3: With `start_in` high and the period counter at zero, a coarse tick fires a pulse, and `pulse_out` is 1 from the following cycle. After `start_in` rises, the first pulse therefore begins no more than COARSE_DIV+1 cycles later.
- R4: A pulse stays high for PULSE_TICKS fine ticks, counted from the first fine tick after the firing tick. `pulse_out` falls on the cycle after the last of those ticks. The width in clocks is therefore between (PULSE_TICKS-1)*FINE_DIV+1 and PULSE_TICKS*FINE_DIV.
- R5: With the short rate held (`rate_long` = 0 at firing), consecutive pulse rising edges are SHORT_MOD*COARSE_DIV clocks apart.
- R6: With the long rate held (`rate_long` = 1 at firing), consecutive pulse rising edges are LONG_MOD*COARSE_DIV clocks apart.
- R7: `rate_long` is sampled only when a pulse fires. A change in the middle of a period leaves that period at its old length and applies from the next firing.
- R8: When `start_in` is low at a clock edge, `pulse_out` and `active_led` are 0 from the next cycle. This cuts short any pulse in progress. The period counter returns to zero, so a later restart behaves as in R3.
- R9: The fine and coarse ticks run freely from reset with periods of exactly FINE_DIV and COARSE_DIV clocks, whatever the state of `start_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_in | input | 1 | Generation enable level, synchronous to clk |
| rate_long | input | 1 | 0 selects the short period, 1 selects the long period |
| pulse_out | output | 1 | Periodic pulse output |
| active_led | output | 1 | High while generation is enabled |

## Verification
A wrong period count or a wrong latched rate only shows up at the next pulse rising edge. Depending on the rate, that can be up to LONG_MOD coarse ticks later, so the bench measures whole intervals and covers a rate change in the middle of a period. A width counter that is off by one moves the falling edge by a full fine tick within the pulse. A stale enable state shows up one cycle after start falls, as a pulse or indicator that is still high. The behavioural reference model is compared with both outputs on every cycle, so any of these faults is reported in the cycle where it first appears.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

  typedef struct packed {
    logic fine;
    logic coarse;
  } tick_pair_t;

  // Number of coarse ticks in one repetition period for the chosen rate.
  function automatic int unsigned period_ticks(logic long_sel,
                                               int unsigned short_mod,
                                               int unsigned long_mod);
    return long_sel ? long_mod : short_mod;
  endfunction

  // True when the given phase is the final coarse tick of a period.
  function automatic logic period_last(int unsigned phase, logic long_sel,
                                       int unsigned short_mod,
                                       int unsigned long_mod);
    return phase == period_ticks(long_sel, short_mod, long_mod) - 1;
  endfunction

endpackage

// File: rtl/gpt_tick_divider.sv
module gpt_tick_divider #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  // R9: the counter never leaves its range, so the tick period is exact
  a_r9_div_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  // R9: a tick is always followed by a restart of the count
  a_r9_tick_restart: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0));
endmodule

// File: rtl/gpt_period_seq.sv
module gpt_period_seq
  import gpt_pkg::*;
#(
  parameter int unsigned SHORT_MOD = 16,
  parameter int unsigned LONG_MOD  = 62
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic coarse_tick,
  input  logic rate_long,
  output logic fire
);
  localparam int unsigned MAXMOD = (LONG_MOD > SHORT_MOD) ? LONG_MOD : SHORT_MOD;
  localparam int unsigned PHW = $clog2(MAXMOD);

  logic [PHW-1:0] phase_q;
  logic           long_q;
  logic           wrap;

  assign fire = run && coarse_tick && (phase_q == '0);
  assign wrap = period_last(int'(phase_q), long_q, SHORT_MOD, LONG_MOD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      long_q  <= 1'b0;
    end else if (!run) begin
      phase_q <= '0;
    end else if (coarse_tick) begin
      if (fire) long_q <= rate_long;
      phase_q <= wrap ? '0 : phase_q + 1'b1;
    end
  end

  // R5/R6: the phase stays below the modulus held for this period
  a_r6_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(phase_q) < int'(period_ticks(long_q, SHORT_MOD, LONG_MOD)));
  // R7: the held rate changes only on a firing tick
  a_r7_rate_held: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(long_q));
  // R8: after a cycle without run, the period restarts from zero
  a_r8_phase_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (phase_q == '0));
endmodule

// File: rtl/gpt_pulse_shaper.sv
module gpt_pulse_shaper #(
  parameter int unsigned PULSE_TICKS = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fire,
  input  logic fine_tick,
  output logic pulse
);
  localparam int unsigned WW = $clog2(PULSE_TICKS + 1);
  localparam logic [WW-1:0] WLAST = WW'(PULSE_TICKS - 1);

  logic [WW-1:0] wcnt_q;
  logic          pulse_q;

  assign pulse = pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      wcnt_q  <= '0;
    end else if (!run) begin
      pulse_q <= 1'b0;
      wcnt_q  <= '0;
    end else if (fire) begin
      pulse_q <= 1'b1;
      wcnt_q  <= '0;
    end else if (pulse_q && fine_tick) begin
      if (wcnt_q == WLAST) begin
        pulse_q <= 1'b0;
        wcnt_q  <= '0;
      end else begin
        wcnt_q <= wcnt_q + 1'b1;
      end
    end
  end

  // R3: a pulse can only begin after a firing event
  a_r3_rise_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_q) |-> $past(fire));
  // R4: the width count stays within the configured tick count
  a_r4_width_bound: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt_q <= WLAST);
  // R4: an idle shaper holds a cleared width count
  a_r4_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_q |-> (wcnt_q == '0));
endmodule

// File: rtl/gated_pulse_train.sv
module gated_pulse_train
  import gpt_pkg::*;
#(
  parameter int unsigned FINE_DIV    = 250000,
  parameter int unsigned COARSE_DIV  = 16375000,
  parameter int unsigned PULSE_TICKS = 25,
  parameter int unsigned SHORT_MOD   = 16,
  parameter int unsigned LONG_MOD    = 62
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_in,
  input  logic rate_long,
  output logic pulse_out,
  output logic active_led
);
  tick_pair_t ticks;
  logic       fire;
  logic       active_q;

  for (genvar i = 0; i < 2; i++) begin : g_div
    logic t;
    gpt_tick_divider #(.DIV(i == 0 ? FINE_DIV : COARSE_DIV)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (t)
    );
    if (i == 0) begin : g_fine
      assign ticks.fine = t;
    end else begin : g_coarse
      assign ticks.coarse = t;
    end
  end

  gpt_period_seq #(.SHORT_MOD(SHORT_MOD), .LONG_MOD(LONG_MOD)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (start_in),
    .coarse_tick(ticks.coarse),
    .rate_long  (rate_long),
    .fire       (fire)
  );

  gpt_pulse_shaper #(.PULSE_TICKS(PULSE_TICKS)) u_shape (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (start_in),
    .fire     (fire),
    .fine_tick(ticks.fine),
    .pulse    (pulse_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= start_in;
  end

  assign active_led = active_q;

  // R8: a low start clears both outputs on the next cycle
  a_r8_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !start_in |=> (!pulse_out && !active_led));
  // R2: the indicator follows start by one cycle
  a_r2_led_follow: assert property (@(posedge clk) disable iff (!rst_n)
    start_in |=> active_led);
  // R3: pulses only appear while the indicator is on
  a_r3_pulse_needs_led: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_out |-> active_led);
endmodule

// File: tb/gated_pulse_train_test.sv
`timescale 1ns/1ps
module gated_pulse_train_test;
  localparam int FD = 4;
  localparam int CD = 262;
  localparam int PW = 25;
  localparam int SM = 16;
  localparam int LM = 62;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_in = 1'b0;
  logic rate_long = 1'b0;
  logic pulse_out, active_led;

  gated_pulse_train #(.FINE_DIV(FD), .COARSE_DIV(CD), .PULSE_TICKS(PW),
                      .SHORT_MOD(SM), .LONG_MOD(LM)) uut (
    .clk(clk), .rst_n(rst_n), .start_in(start_in), .rate_long(rate_long),
    .pulse_out(pulse_out), .active_led(active_led));

  always #2 clk = ~clk;

  int n_vec = 0, n_bad = 0, cyc = 0;
  string req = "R1";

  // behavioural reference
  int  mn = 0, m_phase = 0, m_w = 0;
  bit  m_pulse = 0, m_act = 0, m_long = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mn = 0; m_phase = 0; m_w = 0; m_pulse = 0; m_act = 0; m_long = 0;
    end else begin
      bit ft, ct;
      ft = (mn % FD) == FD - 1;
      ct = (mn % CD) == CD - 1;
      mn++;
      m_act = start_in;
      if (!start_in) begin
        m_phase = 0; m_pulse = 0; m_w = 0;
      end else begin
        if (ct && m_phase == 0) begin
          m_pulse = 1; m_w = 0; m_long = rate_long;
        end else if (ft && m_pulse) begin
          if (m_w == PW - 1) begin m_pulse = 0; m_w = 0; end
          else m_w++;
        end
        if (ct) m_phase = (m_phase == (m_long ? LM : SM) - 1) ? 0 : m_phase + 1;
      end
    end
  end

  task automatic check(string r, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: got %0d expected %0d", r, cyc, act, exp);
    end
  endtask

  task automatic check_range(string r, int act, int lo, int hi);
    n_vec++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: got %0d expected %0d..%0d", r, cyc, act, lo, hi);
    end
  endtask

  int rise_cnt = 0, last_rise = 0, prev_rise = 0, last_width = 0;
  bit prev_p = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      check("R1 pulse in reset", int'(pulse_out), 0);
      check("R1 led in reset", int'(active_led), 0);
    end else begin
      check({req, " pulse vs model"}, int'(pulse_out), int'(m_pulse));
      check({req, " led vs model"}, int'(active_led), int'(m_act));
      if (pulse_out && !prev_p) begin
        prev_rise = last_rise; last_rise = cyc; rise_cnt++;
      end
      if (!pulse_out && prev_p) last_width = cyc - last_rise;
      prev_p = pulse_out;
    end
    if (cyc > 190000) begin
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d: got running expected done", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic wait_rise();
    int target;
    target = rise_cnt + 1;
    while (rise_cnt < target) @(negedge clk);
  endtask

  initial begin
    int t0, rc;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pulse after reset", int'(pulse_out), 0);
    check("R1 led after reset", int'(active_led), 0);
    req = "R9";
    repeat (3 * CD) @(negedge clk);
    check("R9 idle no pulse", rise_cnt, 0);

    req = "R3";
    start_in = 1'b1; t0 = cyc;
    @(negedge clk); @(negedge clk);
    check("R2 led on", int'(active_led), 1);
    wait_rise();
    check_range("R3 first pulse delay", last_rise - t0, 1, CD + 2);

    req = "R5";
    wait_rise();
    check("R5 short interval", last_rise - prev_rise, SM * CD);
    check_range("R4 pulse width", last_width, (PW - 1) * FD + 1, PW * FD);
    wait_rise();
    check("R5 short interval again", last_rise - prev_rise, SM * CD);
    check_range("R4 pulse width again", last_width, (PW - 1) * FD + 1, PW * FD);

    req = "R7";
    repeat (500) @(negedge clk);
    rate_long = 1'b1;
    wait_rise();
    check("R7 running short period kept", last_rise - prev_rise, SM * CD);
    req = "R6";
    wait_rise();
    check("R6 long interval", last_rise - prev_rise, LM * CD);
    req = "R7";
    repeat (300) @(negedge clk);
    rate_long = 1'b0;
    wait_rise();
    check("R7 running long period kept", last_rise - prev_rise, LM * CD);
    wait_rise();
    check("R7 short applies after firing", last_rise - prev_rise, SM * CD);

    req = "R8";
    repeat (10) @(negedge clk);
    check("R8 pulse in progress", int'(pulse_out), 1);
    start_in = 1'b0;
    @(negedge clk);
    check("R8 pulse cut", int'(pulse_out), 0);
    check("R8 led off", int'(active_led), 0);
    rc = rise_cnt;
    repeat (3 * CD) @(negedge clk);
    check("R8 no pulses while stopped", rise_cnt, rc);
    start_in = 1'b1; t0 = cyc;
    wait_rise();
    check_range("R8 restart from zero", last_rise - t0, 1, CD + 2);
    wait_rise();
    check("R5 interval after restart", last_rise - prev_rise, SM * CD);

    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule